// File: doc/BRIEF.md
# Costas Carrier Derotation Loop

This block takes the carrier frequency and phase offset out of a stream of complex baseband samples. Each incoming I/Q sample is multiplied, as a complex number, by the conjugate of a numerically controlled oscillator's phasor. The oscillator takes its cosine and sine from a quarter-wave lookup table. The derotated sample is registered and driven out. Its on-chip flag travels with it.

A four-phase Costas detector forms a phase error, but only from samples flagged as on-chip. It multiplies the sign of one rail by the value of the other. In binary mode only the in-phase term is used. In quaternary mode both rails contribute. The error drives a proportional-plus-integral loop filter whose output is the oscillator's frequency word, which closes the loop. When control is handed over from an acquisition loop, a load strobe copies in the starting phase and frequency instead of starting from zero.

Top module: `costas_derot`

## Requirements
- R1: While reset is held and directly after it, out_i, out_q, out_end and out_err are zero, and out_phase is 0.
- R2: With oscillator phase θ, whose top 6 bits s address a table of amplitude 127 (cos ≈ 127·cos(2πs/64), sin ≈ 127·sin(2πs/64)), one clock after a sample is taken the outputs are out_i = (in_i·cos + in_q·sin + 64) >>> 7 and out_q = (in_q·cos − in_i·sin + 64) >>> 7. out_end equals in_end delayed by one clock.
- R3: Mixer results outside the 8-bit signed range are clamped to 127 or −128.
- R4: On every clock without a load, out_phase advances modulo 2^16 by the frequency word. The frequency word is the integer part of the integrator plus the proportional term. With no on-chip samples, the phase therefore steps by the loaded frequency, which may be negative.
- R5: With mode = 1 (quaternary), out_err = sgn(out_i)·out_q − sgn(out_q)·out_i while out_end = 1. A value of zero counts as positive. While out_end = 0, out_err is 0 and the loop state does not change.
- R6: With mode = 0 (binary), out_err = sgn(out_i)·out_q while out_end = 1, with sgn(0) = +1.
- R7: An error e presented at a clock edge adds e·16 to that edge's phase step and adds e·4 to the integrator. The integrator holds 8 fractional bits. From the next edge on, the frequency word grows by floor(integrator / 256).
- R8: A load strobe sets out_phase to ld_phase and the integrator to ld_freq·256 at the next edge. The load overrides any error present at that edge.
- R9: In binary mode with a constant on-chip input of (70, 70), the loop settles within 3000 clocks to |out_q| ≤ 16 and |out_i| ≥ 80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | 0 = binary detector, 1 = quaternary detector |
| in_i | input | 8 | In-phase input sample, signed |
| in_q | input | 8 | Quadrature input sample, signed |
| in_end | input | 1 | Marks the input sample as an on-chip sample |
| ld | input | 1 | Handover strobe: load phase and frequency |
| ld_phase | input | 16 | Starting oscillator phase |
| ld_freq | input | 16 | Starting frequency word, signed |
| out_i | output | 8 | Derotated in-phase sample, signed |
| out_q | output | 8 | Derotated quadrature sample, signed |
| out_end | output | 1 | On-chip flag aligned with out_i/out_q |
| out_err | output | 10 | Phase detector error, signed |
| out_phase | output | 16 | Oscillator phase accumulator |

## Verification
The mixer is swept over all 64 table sectors with frozen phase. Each sector gets five input vectors: two pure axes, a mixed vector and both diagonals. The axes separate cosine from sine and catch quadrant folding. The diagonals at 45° drive the clamp. The detector is swept over a 7×7 grid that includes zero, ±1 and the rail extremes, in both modes. The grid separates the sign-of-zero rule and the binary and quaternary forms. The same runs follow the phase over two edges, which separates the proportional step from the floored integrator step. Frequency stepping with a positive and a negative word, idle off-chip traffic, a load that collides with a live error, and a closed-loop settle cover wrap-around, hold, load priority and the sign of the feedback.

// File: rtl/cdl_pkg.sv
`timescale 1ns/1ps
package cdl_pkg;
   typedef enum logic {
      DET_BIN  = 1'b0,
      DET_QUAD = 1'b1
   } det_mode_e;
endpackage

// File: rtl/cdl_sincos.sv
`timescale 1ns/1ps
// Quarter-wave cosine/sine table addressed by the top phase bits.
module cdl_sincos #(
   parameter int ADR_W = 6,
   parameter int AMP_W = 8
) (
   input  logic [ADR_W-1:0]        addr,
   output logic signed [AMP_W-1:0] cos_o,
   output logic signed [AMP_W-1:0] sin_o
);
   localparam int     IDX_W = ADR_W - 2;
   localparam int     QN    = 1 << IDX_W;
   localparam longint AMAX  = (longint'(1) << (AMP_W - 1)) - 1;

   if (ADR_W < 3) begin : g_bad_adr
      $error("cdl_sincos: ADR_W must be at least 3");
   end
   if (AMP_W < 4) begin : g_bad_amp
      $error("cdl_sincos: AMP_W must be at least 4");
   end

   // Rational sine approximation over a quarter turn, index k of QN.
   function automatic logic [AMP_W-1:0] quarter_sine(input int k);
      longint d, p, den, v;
      d   = longint'(90) * k;
      p   = d * (longint'(180) * QN - d);
      den = longint'(40500) * QN * QN - p;
      v   = (4 * AMAX * p + den / 2) / den;
      return v[AMP_W-1:0];
   endfunction

   logic [AMP_W-1:0] tbl [QN+1];
   for (genvar k = 0; k <= QN; k++) begin : g_tbl
      assign tbl[k] = quarter_sine(k);
   end

   logic [1:0]              quad;
   logic [IDX_W:0]          fwd, rev;
   logic signed [AMP_W-1:0] a, b;

   assign quad = addr[ADR_W-1 -: 2];
   assign fwd  = {1'b0, addr[IDX_W-1:0]};
   assign rev  = (IDX_W+1)'(QN) - fwd;
   assign a    = signed'(tbl[fwd]);
   assign b    = signed'(tbl[rev]);

   always_comb begin
      unique case (quad)
         2'd0:    begin sin_o =  a; cos_o =  b; end
         2'd1:    begin sin_o =  b; cos_o = -a; end
         2'd2:    begin sin_o = -a; cos_o = -b; end
         default: begin sin_o = -b; cos_o =  a; end
      endcase
   end
endmodule

// File: rtl/cdl_mixer.sv
`timescale 1ns/1ps
// Multiply by the conjugate phasor, round, clamp back to IN_W bits.
module cdl_mixer #(
   parameter int IN_W  = 8,
   parameter int AMP_W = 8
) (
   input  logic signed [IN_W-1:0]  xi,
   input  logic signed [IN_W-1:0]  xq,
   input  logic signed [AMP_W-1:0] c,
   input  logic signed [AMP_W-1:0] s,
   output logic signed [IN_W-1:0]  yi,
   output logic signed [IN_W-1:0]  yq
);
   localparam int PW = IN_W + AMP_W + 1;
   localparam int SH = AMP_W - 1;
   localparam logic signed [PW-1:0] HI   = PW'((1 << (IN_W - 1)) - 1);
   localparam logic signed [PW-1:0] LO   = -HI - PW'(1);
   localparam logic signed [PW-1:0] HALF = PW'(1 << (SH - 1));

   function automatic logic signed [IN_W-1:0] clamp(input logic signed [PW-1:0] v);
      if (v > HI)      return IN_W'(HI);
      else if (v < LO) return IN_W'(LO);
      else             return IN_W'(v);
   endfunction

   logic signed [PW-1:0] xi_e, xq_e, c_e, s_e, acc_i, acc_q;

   always_comb begin
      xi_e  = PW'(xi);
      xq_e  = PW'(xq);
      c_e   = PW'(c);
      s_e   = PW'(s);
      acc_i = ((xi_e * c_e) + (xq_e * s_e) + HALF) >>> SH;
      acc_q = ((xq_e * c_e) - (xi_e * s_e) + HALF) >>> SH;
      yi    = clamp(acc_i);
      yq    = clamp(acc_q);
   end
endmodule

// File: rtl/cdl_phase_det.sv
`timescale 1ns/1ps
// Sign-times-value Costas detector; form selected by mode.
module cdl_phase_det #(
   parameter int IN_W = 8,
   localparam int ERR_W = IN_W + 2
) (
   input  logic                   en,
   input  cdl_pkg::det_mode_e     mode,
   input  logic signed [IN_W-1:0] yi,
   input  logic signed [IN_W-1:0] yq,
   output logic signed [ERR_W-1:0] err
);
   logic signed [ERR_W-1:0] yi_e, yq_e, t_i, t_q;

   always_comb begin
      yi_e = ERR_W'(yi);
      yq_e = ERR_W'(yq);
      t_i  = yi[IN_W-1] ? -yq_e : yq_e;
      t_q  = yq[IN_W-1] ? -yi_e : yi_e;
      if (!en)                          err = '0;
      else if (mode == cdl_pkg::DET_QUAD) err = t_i - t_q;
      else                              err = t_i;
   end
endmodule

// File: rtl/cdl_loop_nco.sv
`timescale 1ns/1ps
// Proportional-plus-integral filter feeding a phase accumulator.
module cdl_loop_nco #(
   parameter int PH_W   = 16,
   parameter int ERR_W  = 10,
   parameter int KP_SH  = 4,
   parameter int KI_SH  = 2,
   parameter int FRAC_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld,
   input  logic [PH_W-1:0]         ld_phase,
   input  logic signed [PH_W-1:0]  ld_freq,
   input  logic signed [ERR_W-1:0] err,
   output logic [PH_W-1:0]         phase
);
   localparam int INT_W = PH_W + FRAC_W;

   if (ERR_W > PH_W) begin : g_bad_err
      $error("cdl_loop_nco: ERR_W must not exceed PH_W");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("cdl_loop_nco: FRAC_W must be at least 1");
   end

   logic signed [INT_W-1:0] integ, err_int;
   logic signed [PH_W-1:0]  err_ph, prop;
   logic [PH_W-1:0]         freq;

   always_comb begin
      err_int = INT_W'(err) <<< KI_SH;
      err_ph  = PH_W'(err);
      prop    = err_ph <<< KP_SH;
      freq    = integ[INT_W-1:FRAC_W] + prop;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         integ <= '0;
         phase <= '0;
      end else if (ld) begin
         integ <= {ld_freq, {FRAC_W{1'b0}}};
         phase <= ld_phase;
      end else begin
         integ <= integ + err_int;
         phase <= phase + freq;
      end
   end

   // R8: a load takes both phase and frequency, whatever the error
   a_r8_load_takes_over: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ld)) |->
         (phase == $past(ld_phase) && integ[INT_W-1:FRAC_W] == $past(ld_freq)));

   // R5: without an error and without a load the integrator keeps its value
   a_r5_integ_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ld) && $past(err) == '0) |-> $stable(integ));
endmodule

// File: rtl/costas_derot.sv
`timescale 1ns/1ps
module costas_derot #(
   parameter int IN_W   = 8,
   parameter int PH_W   = 16,
   parameter int LUT_AW = 6,
   parameter int LUT_W  = 8,
   parameter int KP_SH  = 4,
   parameter int KI_SH  = 2,
   parameter int FRAC_W = 8,
   localparam int ERR_W = IN_W + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mode,
   input  logic signed [IN_W-1:0]  in_i,
   input  logic signed [IN_W-1:0]  in_q,
   input  logic                    in_end,
   input  logic                    ld,
   input  logic [PH_W-1:0]         ld_phase,
   input  logic signed [PH_W-1:0]  ld_freq,
   output logic signed [IN_W-1:0]  out_i,
   output logic signed [IN_W-1:0]  out_q,
   output logic                    out_end,
   output logic signed [ERR_W-1:0] out_err,
   output logic [PH_W-1:0]         out_phase
);
   if (LUT_AW > PH_W) begin : g_bad_lut
      $error("costas_derot: LUT_AW must not exceed PH_W");
   end
   if (IN_W < 2) begin : g_bad_in
      $error("costas_derot: IN_W must be at least 2");
   end

   logic signed [LUT_W-1:0] nco_c, nco_s;
   logic signed [IN_W-1:0]  mix_i, mix_q;
   cdl_pkg::det_mode_e      det_mode;

   assign det_mode = cdl_pkg::det_mode_e'(mode);

   cdl_sincos #(.ADR_W(LUT_AW), .AMP_W(LUT_W)) u_lut (
      .addr  (out_phase[PH_W-1 -: LUT_AW]),
      .cos_o (nco_c),
      .sin_o (nco_s)
   );

   cdl_mixer #(.IN_W(IN_W), .AMP_W(LUT_W)) u_mix (
      .xi (in_i),
      .xq (in_q),
      .c  (nco_c),
      .s  (nco_s),
      .yi (mix_i),
      .yq (mix_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_i   <= '0;
         out_q   <= '0;
         out_end <= 1'b0;
      end else begin
         out_i   <= mix_i;
         out_q   <= mix_q;
         out_end <= in_end;
      end
   end

   cdl_phase_det #(.IN_W(IN_W)) u_det (
      .en   (out_end),
      .mode (det_mode),
      .yi   (out_i),
      .yq   (out_q),
      .err  (out_err)
   );

   cdl_loop_nco #(
      .PH_W(PH_W), .ERR_W(ERR_W), .KP_SH(KP_SH), .KI_SH(KI_SH), .FRAC_W(FRAC_W)
   ) u_loop (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (ld),
      .ld_phase (ld_phase),
      .ld_freq  (ld_freq),
      .err      (out_err),
      .phase    (out_phase)
   );

   // R2: the on-chip flag is delayed by exactly one clock
   a_r2_end_delay: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_end == $past(in_end)));

   // R5: off-chip samples never produce an error
   a_r5_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !out_end |-> (out_err == '0));

   // R4: with no error and no load, phase steps by a constant amount
   a_r4_steady_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && !$past(ld) && !$past(ld, 2) && !$past(out_end) && !$past(out_end, 2))
      |-> ((out_phase - $past(out_phase)) == ($past(out_phase) - $past(out_phase, 2))));
endmodule

// File: tb/sim_costas_derot.sv
`timescale 1ns/1ps
module sim_costas_derot;
   logic              clk = 1'b0, rst_n = 1'b0, mode = 1'b0, in_end = 1'b0, ld = 1'b0;
   logic signed [7:0] in_i = '0, in_q = '0;
   logic [15:0]       ld_phase = '0;
   logic signed [15:0] ld_freq = '0;
   logic signed [7:0] out_i, out_q;
   logic              out_end;
   logic signed [9:0] out_err;
   logic [15:0]       out_phase;
   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   costas_derot u0 (
      .clk(clk), .rst_n(rst_n), .mode(mode), .in_i(in_i), .in_q(in_q), .in_end(in_end),
      .ld(ld), .ld_phase(ld_phase), .ld_freq(ld_freq), .out_i(out_i), .out_q(out_q),
      .out_end(out_end), .out_err(out_err), .out_phase(out_phase)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load(input int p, input int f);
      ld = 1'b1; ld_phase = 16'(p); ld_freq = 16'(f);
      tick();
      ld = 1'b0;
   endtask

   function automatic int tcos(input int s);
      return $rtoi($floor(127.0 * $cos(2.0 * 3.14159265358979 * s / 64.0) + 0.5));
   endfunction
   function automatic int tsin(input int s);
      return $rtoi($floor(127.0 * $sin(2.0 * 3.14159265358979 * s / 64.0) + 0.5));
   endfunction
   function automatic int clamp8(input int v);
      return (v > 127) ? 127 : ((v < -128) ? -128 : v);
   endfunction
   function automatic int sg(input int v);
      return (v < 0) ? -1 : 1;
   endfunction
   function automatic int absv(input int v);
      return (v < 0) ? -v : v;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int vi[5], vq[5], grid[7];
      vi = '{100, 0, -77, 127, -128};
      vq = '{0, 100, 45, 127, -128};
      grid = '{-128, -100, -1, 0, 1, 50, 127};
      repeat (3) @(negedge clk);
      // R1 reset values
      chk(out_i == 0 && out_q == 0, "R1 samples", int'(out_i), 0);
      chk(out_end == 0 && out_err == 0, "R1 flag/err", int'(out_err), 0);
      rst_n = 1'b1;
      chk(out_phase == 0, "R1 phase", int'(out_phase), 0);

      // R2 mixer sweep over all sectors
      for (int s = 0; s < 64; s++) begin
         for (int k = 0; k < 5; k++) begin
            int c, sn, ei, eq;
            in_end = 1'b0;
            load((s << 10) | ((s * 37) & 16'h3FF), 0);
            in_i = 8'(vi[k]); in_q = 8'(vq[k]);
            tick();
            c = tcos(s); sn = tsin(s);
            ei = clamp8((vi[k] * c + vq[k] * sn + 64) >>> 7);
            eq = clamp8((vq[k] * c - vi[k] * sn + 64) >>> 7);
            chk(absv(int'(out_i) - ei) <= 2, "R2 out_i", int'(out_i), ei);
            chk(absv(int'(out_q) - eq) <= 2, "R2 out_q", int'(out_q), eq);
         end
      end

      // R3 clamp at 45 degrees
      load(8 << 10, 0);
      in_i = 8'sd127; in_q = 8'sd127; tick();
      chk(out_i == 127, "R3 clamp high", int'(out_i), 127);
      in_i = -8'sd128; in_q = -8'sd128; tick();
      chk(out_i == -128, "R3 clamp low", int'(out_i), -128);

      // R5/R6/R7 detector grid in both modes
      for (int m = 0; m < 2; m++) begin
         for (int a = 0; a < 7; a++) begin
            for (int b = 0; b < 7; b++) begin
               int ei, eq, e, ph;
               mode = m[0]; in_end = 1'b0;
               load(0, 0);
               in_i = 8'(grid[a]); in_q = 8'(grid[b]); in_end = 1'b1;
               tick();
               ei = (grid[a] * 127 + 64) >>> 7;
               eq = (grid[b] * 127 + 64) >>> 7;
               e = (m == 1) ? (sg(ei) * eq - sg(eq) * ei) : (sg(ei) * eq);
               chk(out_end == 1'b1, "R2 end flag", int'(out_end), 1);
               chk(out_i == ei && out_q == eq, "R2 zero phase", int'(out_i), ei);
               chk(out_err == e, (m == 1) ? "R5 quad err" : "R6 bin err", int'(out_err), e);
               chk(out_phase == 0, "R7 no step yet", int'(out_phase), 0);
               in_end = 1'b0;
               tick();
               ph = (e * 16) & 16'hFFFF;
               chk(out_phase == ph, "R7 proportional", int'(out_phase), ph);
               tick();
               ph = (e * 16 + ((e * 4) >>> 8)) & 16'hFFFF;
               chk(out_phase == ph, "R7 integral", int'(out_phase), ph);
            end
         end
      end

      // R5 off-chip traffic leaves the loop alone
      mode = 1'b1; in_end = 1'b0;
      load(16'h1000, 0);
      for (int n = 0; n < 20; n++) begin
         in_i = 8'($urandom); in_q = 8'($urandom);
         tick();
         chk(out_err == 0, "R5 idle err", int'(out_err), 0);
         chk(out_phase == 16'h1000, "R5 idle phase", int'(out_phase), 16'h1000);
      end

      // R4 frequency stepping with wrap, positive and negative
      load(16'hFFF0, 16'h1234);
      for (int n = 1; n <= 10; n++) begin
         int ph;
         tick();
         ph = (16'hFFF0 + n * 16'h1234) & 16'hFFFF;
         chk(out_phase == ph, "R4 step up", int'(out_phase), ph);
      end
      load(16'h0100, -300);
      for (int n = 1; n <= 5; n++) begin
         int ph;
         tick();
         ph = (16'h0100 - n * 300) & 16'hFFFF;
         chk(out_phase == ph, "R4 step down", int'(out_phase), ph);
      end

      // R8 load collides with a live error
      load(0, 0);
      in_i = 8'sd100; in_q = -8'sd40; in_end = 1'b1;
      tick();
      chk(out_err != 0, "R8 setup err", int'(out_err), 1);
      in_end = 1'b0;
      load(16'h4000, 5);
      chk(out_phase == 16'h4000, "R8 load phase", int'(out_phase), 16'h4000);
      tick();
      chk(out_phase == 16'h4005, "R8 load freq", int'(out_phase), 16'h4005);

      // R9 closed-loop settle in binary mode
      mode = 1'b0;
      load(0, 0);
      in_i = 8'sd70; in_q = 8'sd70; in_end = 1'b1;
      repeat (3000) tick();
      chk(absv(int'(out_q)) <= 16, "R9 residual q", int'(out_q), 0);
      chk(absv(int'(out_i)) >= 80, "R9 magnitude i", int'(out_i), 98);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule